// File: doc/BRIEF.md
# Execution Range Guard

This block watches the instruction fetch stream of a processor and raises a flag when code is fetched from a protected window of RAM. Software sets the window with two full-width address registers, the lowest and the highest protected address. It then arms the guard through a control register. From the moment the guard is armed, it can no longer be disarmed. The two bound registers are also frozen, so the protection stays in place until the next reset.

The guard only looks at instruction fetches. Data loads and stores never reach it. A fetch that lands inside the window while the guard is armed sets a violation output. The output stays set until reset, and the surrounding system uses it to halt or trap the processor.

The configuration port is a plain write strobe with a byte offset and a data word. The guard accepts every write in the cycle it is presented, so there is no back-pressure. The fetch input is a plain valid qualifier with an address, and it is likewise never stalled.

Top module: `exec_guard`

## Requirements
- R1: Reset disarms the guard, clears both bound registers to zero and drops `exec_violation`.
- R2: A write to offset 0x180 with data bit 0 set arms the guard from the next cycle. A write there with bit 0 clear has no effect, whatever the other bits hold.
- R3: Once armed, the guard stays armed until reset, including after later writes of 0 to offset 0x180.
- R4: While the guard is disarmed, a write to offset 0x184 loads the lower bound and a write to offset 0x188 loads the upper bound. Both bounds are full 32-bit values.
- R5: While the guard is armed, writes to offsets 0x184 and 0x188 are ignored.
- R6: A fetch address A is inside the window when lower <= A <= upper, using an unsigned comparison that includes both ends.
- R7: When the lower bound exceeds the upper bound, no address is inside the window.
- R8: An armed guard that sees `fetch_valid` high with an address inside the window raises `exec_violation` after the next rising clock edge. An address presented with `fetch_valid` low is ignored.
- R9: `exec_violation` stays high until reset.
- R10: While the guard is disarmed, no fetch raises `exec_violation`.
- R11: Writes to any offset other than the three above change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe, always accepted |
| cfg_wr_ofs | input | 12 | Byte offset of the configuration write |
| cfg_wr_data | input | 32 | Configuration write data |
| fetch_valid | input | 1 | An instruction fetch is presented this cycle |
| fetch_addr | input | 32 | Address of the instruction fetch |
| exec_violation | output | 1 | Sticky flag: execution was attempted inside the armed window |

## Verification
A configuration write takes effect at the rising edge that samples it. It therefore governs fetches from the following cycle on. A fetch in the same cycle as the arming write is still judged as disarmed.

A qualifying fetch shows up on `exec_violation` one edge after it is presented. The bench drives every input at the falling edge and reads the flag 1 ns after the next rising edge. It also reads the flag just before that edge, which checks that the output is registered and not combinational.

Random scenarios cover bounds placed close together, swapped bounds and addresses one step either side of each bound. Each scenario is compared with a reference model that the bench keeps for itself.

// File: rtl/xg_pkg.sv
package xg_pkg;
  // register select produced by the offset decoder
  typedef enum logic [1:0] {
    XG_SEL_NONE,
    XG_SEL_CTRL,
    XG_SEL_LO,
    XG_SEL_HI
  } xg_sel_e;

  localparam int XG_OFS_W     = 12;
  localparam int XG_CTRL_OFS  = 'h180;
  localparam int XG_LO_OFS    = 'h184;
  localparam int XG_HI_OFS    = 'h188;
  localparam int XG_ARM_BIT   = 0;
endpackage

// File: rtl/xg_regs.sv
module xg_regs
  import xg_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFS_W    = XG_OFS_W,
  parameter int CTRL_OFS = XG_CTRL_OFS,
  parameter int LO_OFS   = XG_LO_OFS,
  parameter int HI_OFS   = XG_HI_OFS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  wr_ofs,
  input  logic [ADDR_W-1:0] wr_data,
  output logic              armed,
  output logic [ADDR_W-1:0] lo_q,
  output logic [ADDR_W-1:0] hi_q
);
  localparam logic [OFS_W-1:0] CtrlOfs = OFS_W'(CTRL_OFS);
  localparam logic [OFS_W-1:0] LoOfs   = OFS_W'(LO_OFS);
  localparam logic [OFS_W-1:0] HiOfs   = OFS_W'(HI_OFS);

  xg_sel_e sel;

  always_comb begin
    sel = XG_SEL_NONE;
    if (wr_en) begin
      if (wr_ofs == CtrlOfs)    sel = XG_SEL_CTRL;
      else if (wr_ofs == LoOfs) sel = XG_SEL_LO;
      else if (wr_ofs == HiOfs) sel = XG_SEL_HI;
    end
  end

  // arm bit: set-only
  always_ff @(posedge clk) begin
    if (!rst_n)
      armed <= 1'b0;
    else if (sel == XG_SEL_CTRL && wr_data[XG_ARM_BIT])
      armed <= 1'b1;
  end

  // bounds: frozen while armed
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (!armed) begin
      if (sel == XG_SEL_LO) lo_q <= wr_data;
      if (sel == XG_SEL_HI) hi_q <= wr_data;
    end
  end
endmodule

// File: rtl/xg_match.sv
module xg_match #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic above_lo;
  logic below_hi;

  // unsigned, inclusive on both ends; swapped bounds can never both hold
  always_comb begin
    above_lo = (addr >= lo);
    below_hi = (addr <= hi);
    hit      = above_lo && below_hi;
  end
endmodule

// File: rtl/xg_flag.sv
module xg_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      flag <= 1'b0;
    else if (set)
      flag <= 1'b1;
  end
endmodule

// File: rtl/exec_guard.sv
module exec_guard
  import xg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = XG_OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [OFS_W-1:0]  cfg_wr_ofs,
  input  logic [ADDR_W-1:0] cfg_wr_data,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              exec_violation
);
  logic              armed;
  logic [ADDR_W-1:0] rng_first;
  logic [ADDR_W-1:0] rng_last;
  logic              in_window;
  logic              trip;

  xg_regs #(
    .ADDR_W (ADDR_W),
    .OFS_W  (OFS_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_ofs  (cfg_wr_ofs),
    .wr_data (cfg_wr_data),
    .armed   (armed),
    .lo_q    (rng_first),
    .hi_q    (rng_last)
  );

  xg_match #(
    .ADDR_W (ADDR_W)
  ) u_match (
    .lo   (rng_first),
    .hi   (rng_last),
    .addr (fetch_addr),
    .hit  (in_window)
  );

  assign trip = armed && fetch_valid && in_window;

  xg_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (trip),
    .flag  (exec_violation)
  );
endmodule

// File: rtl/xg_chk.sv
module xg_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_valid,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              exec_violation,
  input logic              armed,
  input logic [ADDR_W-1:0] rng_first,
  input logic [ADDR_W-1:0] rng_last
);
  // R9
  viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_violation |=> exec_violation);

  // R3
  arm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);

  // R5
  range_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> ($stable(rng_first) && $stable(rng_last)));

  // R8
  viol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exec_violation) |-> $past(fetch_valid && armed));

  // R6
  viol_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exec_violation) |-> $past((fetch_addr >= rng_first) && (fetch_addr <= rng_last)));
endmodule

bind exec_guard xg_chk #(.ADDR_W(ADDR_W)) u_xg_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .fetch_valid    (fetch_valid),
  .fetch_addr     (fetch_addr),
  .exec_violation (exec_violation),
  .armed          (armed),
  .rng_first      (rng_first),
  .rng_last       (rng_last)
);

// File: tb/exec_guard_bench.sv
module exec_guard_bench;
  localparam logic [11:0] OFS_CTRL = 12'h180;
  localparam logic [11:0] OFS_LO   = 12'h184;
  localparam logic [11:0] OFS_HI   = 12'h188;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [11:0] cfg_wr_ofs;
  logic [31:0] cfg_wr_data;
  logic        fetch_valid;
  logic [31:0] fetch_addr;
  logic        exec_violation;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference model
  bit        m_armed;
  bit        m_viol;
  bit [31:0] m_lo;
  bit [31:0] m_hi;

  always #5 clk = ~clk;

  exec_guard u_exec_guard (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_wr_en      (cfg_wr_en),
    .cfg_wr_ofs     (cfg_wr_ofs),
    .cfg_wr_data    (cfg_wr_data),
    .fetch_valid    (fetch_valid),
    .fetch_addr     (fetch_addr),
    .exec_violation (exec_violation)
  );

  function automatic bit inside_win(bit [31:0] lo, bit [31:0] hi, bit [31:0] a);
    return (a >= lo) && (a <= hi);
  endfunction

  task automatic check(input logic act, input bit exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: exec_violation=%0b expected %0b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cfg_wr_en = 1'b0; fetch_valid = 1'b0;
    cfg_wr_ofs = '0; cfg_wr_data = '0; fetch_addr = '0;
    @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
    m_armed = 0; m_viol = 0; m_lo = '0; m_hi = '0;
  endtask

  task automatic wr(input logic [11:0] ofs, input logic [31:0] data);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_ofs = ofs; cfg_wr_data = data;
    @(posedge clk);
    if (ofs == OFS_CTRL && data[0]) m_armed = 1;
    if (!m_armed && ofs == OFS_LO) m_lo = data;
    if (!m_armed && ofs == OFS_HI) m_hi = data;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  // presents one fetch; checks the flag just before the edge and 1 ns after
  task automatic fetch(input bit v, input logic [31:0] a, input string req);
    bit pre;
    @(negedge clk);
    fetch_valid = v; fetch_addr = a;
    pre = m_viol;
    #4;
    check(exec_violation, pre, req);
    @(posedge clk);
    if (m_armed && v && inside_win(m_lo, m_hi, a)) m_viol = 1;
    #1;
    check(exec_violation, m_viol, req);
    @(negedge clk);
    fetch_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();

    // R1: reset state, flag low; zeroed bounds give window [0,0]
    check(exec_violation, 1'b0, "R1");
    fetch(1, 32'h4, "R10 disarmed");
    wr(OFS_CTRL, 32'h1);
    fetch(1, 32'h1, "R1 zero bounds");
    fetch(1, 32'h0, "R1 zero bounds");

    // R2: write with bit 0 clear does not arm
    do_reset();
    wr(OFS_LO, 32'h1000); wr(OFS_HI, 32'h1FFF);
    wr(OFS_CTRL, 32'hFFFF_FFFE);
    fetch(1, 32'h1800, "R2 bit0 clear");
    fetch(1, 32'h1000, "R10 disarmed");

    // R11: stray offsets ignored (would move lower bound if aliased)
    wr(12'h084, 32'h0); wr(12'h18C, 32'h0); wr(12'h384, 32'h0);
    wr(OFS_CTRL, 32'h1);
    fetch(1, 32'h0800, "R11 stray offset");
    // R6 boundaries
    fetch(1, 32'h0FFF, "R6 below lower");
    fetch(1, 32'h2000, "R6 above upper");
    // R8: valid low ignored
    fetch(0, 32'h1800, "R8 valid low");
    // R3: clearing write does not disarm
    wr(OFS_CTRL, 32'h0);
    // R5: new bounds ignored while armed
    wr(OFS_LO, 32'h0); wr(OFS_HI, 32'hFFFF_FFFF);
    fetch(1, 32'h0000_0010, "R5 locked bounds");
    fetch(1, 32'h1FFF, "R6 upper inclusive R3 R8");
    // R9: stays high
    for (int i = 0; i < 5; i++) fetch(0, 32'h0, "R9 sticky");

    // R6 lower inclusive, full-width bounds (R4)
    do_reset();
    wr(OFS_LO, 32'hFFFF_FFF0); wr(OFS_HI, 32'hFFFF_FFFF);
    wr(OFS_CTRL, 32'h1);
    fetch(1, 32'hFFFF_FFEF, "R4 full width");
    fetch(1, 32'hFFFF_FFF0, "R6 lower inclusive");

    // R7: swapped bounds match nothing
    do_reset();
    wr(OFS_LO, 32'h3000); wr(OFS_HI, 32'h2000);
    wr(OFS_CTRL, 32'h1);
    fetch(1, 32'h2000, "R7 swapped");
    fetch(1, 32'h2800, "R7 swapped");
    fetch(1, 32'h3000, "R7 swapped");

    // arm and fetch in the same cycle: fetch judged disarmed (R2)
    do_reset();
    wr(OFS_LO, 32'h10); wr(OFS_HI, 32'h20);
    @(negedge clk);
    cfg_wr_en = 1; cfg_wr_ofs = OFS_CTRL; cfg_wr_data = 32'h1;
    fetch_valid = 1; fetch_addr = 32'h18;
    @(posedge clk); #1;
    m_armed = 1;
    check(exec_violation, 1'b0, "R2 arm timing");
    @(negedge clk);
    cfg_wr_en = 0; fetch_valid = 0;
    fetch(1, 32'h18, "R8 after arm");

    // constrained random scenarios
    for (int s = 0; s < 60; s++) begin
      logic [31:0] base, lo, hi;
      do_reset();
      base = $urandom;
      lo = base + ($urandom % 16);
      hi = base + ($urandom % 16);
      wr(OFS_LO, lo); wr(OFS_HI, hi);
      for (int k = 0; k < 4; k++) fetch(1, base + ($urandom % 20), "R10 random");
      if ($urandom % 4 != 0) wr(OFS_CTRL, {$urandom, 1'b1} >> 0);
      if ($urandom % 2 == 0) begin
        wr(OFS_LO, $urandom); wr(OFS_HI, $urandom);
      end
      for (int k = 0; k < 16; k++) begin
        logic [31:0] a;
        case ($urandom % 5)
          0: a = lo - 1;
          1: a = hi + 1;
          2: a = lo;
          3: a = hi;
          default: a = base + ($urandom % 20);
        endcase
        fetch(($urandom % 4) != 0, a, "R6 R7 R8 R9 random");
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule